// File: doc/BRIEF.md
# Min-Max Common-Mode Offset Injector

This block modifies the phase references of a three-phase carrier-based modulator so that the active switching states fall in the centre of each sampling interval. A strobe delivers three signed phase samples once per interval. The block finds the largest and the smallest of the three samples and builds one common-mode offset from them: the negative of half their sum. It adds that same offset to every phase. The adjusted references leave on a valid strobe for the per-phase carrier comparators downstream.

Each strobe is handled on its own. The block keeps no history between intervals and does not decide which sector the reference lies in. The work is split over two register stages. The first stage captures the samples together with the offset, which is computed from their extremes. The second stage adds the offset to each phase and clamps the result to the signed sample range. Between strobes the outputs keep their last result.

Top module: `cm_offset_inject`

## Requirements
- R1: Reset is synchronous and active high. It forces `out_valid` to 0 and every phase of `out_ref` to 0.
- R2: A sample captured with `in_valid` high at rising edge k produces `out_valid` high after rising edge k+1, for exactly one cycle per strobe. While no strobe arrives, `out_valid` stays low.
- R3: Phase i sits in bits [16*i+15 : 16*i] of `in_ref` and `out_ref`, in two's complement. Each output is `x_i + ofs`, where `ofs = -floor((max + min) / 2)` and max and min are taken over the three samples of the same strobe. Halving floors toward negative infinity, so (3,0,0) gives (2,-1,-1) and (-3,0,0) gives (-1,2,2).
- R4: An output sum that goes above 32767 is clamped to 32767, and one that goes below -32768 is clamped to -32768; it never wraps. For example (32767,-32768,0) gives (32767,-32767,1).
- R5: When all three samples of a strobe are equal, every output of that strobe is 0.
- R6: When the largest and smallest samples are symmetric about zero, the offset is 0 and each output equals its input.
- R7: Between strobes, `out_ref` keeps its last value. Any change on `in_ref` while `in_valid` is low has no effect on the outputs.
- R8: For any result with no phase clamped, the largest output plus the smallest output equals 0 or 1.
- R9: Strobes on consecutive cycles each produce their own result on consecutive cycles. No result depends on an earlier interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe marking a fresh set of phase samples |
| in_ref | input | 48 | Three signed 16-bit phase samples, phase 0 in the low bits |
| out_valid | output | 1 | One-cycle strobe marking fresh modified references |
| out_ref | output | 48 | Three signed 16-bit modified references, same packing as the input |

## Verification
The assertions check on every cycle that the block has fixed latency and one output pulse per strobe, that the outputs do not move without a strobe, that equal samples come out as zero, that reset clears the outputs, and that every unclamped result is centred. Some behaviour only the bench's scenarios can show, because it needs exact expected values from a model. That covers the floor rounding of odd sums, the clamping at the positive rail, symmetric inputs passing through unchanged, and back-to-back strobes mixed with random input noise between strobes.

// File: rtl/cmoi_pkg.sv
package cmoi_pkg;
  parameter int SAMPLE_W_DEF = 16;
  parameter int PHASES_DEF   = 3;
endpackage

// File: rtl/cmoi_extremes.sv
module cmoi_extremes #(
  parameter int W = 16,
  parameter int N = 3
) (
  input  logic [N*W-1:0]      smp_flat,
  output logic signed [W-1:0] hi,
  output logic signed [W-1:0] lo
);
  logic signed [W-1:0] run_hi [N];
  logic signed [W-1:0] run_lo [N];

  assign run_hi[0] = smp_flat[W-1:0];
  assign run_lo[0] = smp_flat[W-1:0];

  // running comparison chain across the phases
  for (genvar g = 1; g < N; g++) begin : g_cmp
    logic signed [W-1:0] cur;
    assign cur       = smp_flat[g*W +: W];
    assign run_hi[g] = (cur > run_hi[g-1]) ? cur : run_hi[g-1];
    assign run_lo[g] = (cur < run_lo[g-1]) ? cur : run_lo[g-1];
  end

  assign hi = run_hi[N-1];
  assign lo = run_lo[N-1];
endmodule

// File: rtl/cmoi_offset.sv
module cmoi_offset #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] hi,
  input  logic signed [W-1:0] lo,
  output logic signed [W:0]   ofs
);
  logic signed [W:0] sum_w;
  logic signed [W:0] half_w;

  // one extra bit so the sum of the extremes cannot overflow
  assign sum_w  = {hi[W-1], hi} + {lo[W-1], lo};
  // arithmetic shift floors toward negative infinity
  assign half_w = sum_w >>> 1;
  // -half spans [-(2^(W-1)-1), 2^(W-1)], which fits in W+1 bits
  assign ofs    = -half_w;
endmodule

// File: rtl/cmoi_sat_add.sv
module cmoi_sat_add #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] smp,
  input  logic signed [W:0]   ofs,
  output logic [W-1:0]        res
);
  localparam logic signed [W+1:0] MAXV = {3'b000, {(W-1){1'b1}}};
  localparam logic signed [W+1:0] MINV = {3'b111, {(W-1){1'b0}}};

  logic signed [W+1:0] wide;

  assign wide = {{2{smp[W-1]}}, smp} + {ofs[W], ofs};

  always_comb begin
    if (wide > MAXV)      res = MAXV[W-1:0];
    else if (wide < MINV) res = MINV[W-1:0];
    else                  res = wide[W-1:0];
  end
endmodule

// File: rtl/cm_offset_inject.sv
module cm_offset_inject #(
  parameter int W = cmoi_pkg::SAMPLE_W_DEF,
  parameter int N = cmoi_pkg::PHASES_DEF
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [N*W-1:0] in_ref,
  output logic           out_valid,
  output logic [N*W-1:0] out_ref
);
  localparam int OW = W + 1;

  logic signed [W-1:0]  ext_hi;
  logic signed [W-1:0]  ext_lo;
  logic signed [OW-1:0] ofs_c;

  logic                 s1_valid;
  logic [N*W-1:0]       s1_ref;
  logic signed [OW-1:0] s1_ofs;
  logic [N*W-1:0]       sum_c;

  cmoi_extremes #(.W(W), .N(N)) u_ext (
    .smp_flat (in_ref),
    .hi       (ext_hi),
    .lo       (ext_lo)
  );

  cmoi_offset #(.W(W)) u_ofs (
    .hi  (ext_hi),
    .lo  (ext_lo),
    .ofs (ofs_c)
  );

  // stage 1: capture samples with their shared offset
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_ref   <= '0;
      s1_ofs   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_ref <= in_ref;
        s1_ofs <= ofs_c;
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_phase
    cmoi_sat_add #(.W(W)) u_add (
      .smp (s1_ref[g*W +: W]),
      .ofs (s1_ofs),
      .res (sum_c[g*W +: W])
    );
  end

  // stage 2: registered, clamped outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_ref   <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) out_ref <= sum_c;
    end
  end
endmodule

// File: rtl/cmoi_chk.sv
module cmoi_chk #(
  parameter int W = 16,
  parameter int N = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [N*W-1:0] in_ref,
  input logic           out_valid,
  input logic [N*W-1:0] out_ref
);
  localparam int RAIL_HI = (1 << (W-1)) - 1;
  localparam int RAIL_LO = -(1 << (W-1));

  logic [1:0] age;
  logic       in_all_eq;
  logic       any_rail;
  int         o_hi;
  int         o_lo;

  always_ff @(posedge clk) begin
    if (rst)               age <= 2'd0;
    else if (age != 2'd2)  age <= age + 2'd1;
  end

  always_comb begin
    in_all_eq = 1'b1;
    any_rail  = 1'b0;
    o_hi      = RAIL_LO;
    o_lo      = RAIL_HI;
    for (int i = 0; i < N; i++) begin
      int v;
      v = int'($signed(out_ref[i*W +: W]));
      if (in_ref[i*W +: W] != in_ref[W-1:0]) in_all_eq = 1'b0;
      if (v == RAIL_HI || v == RAIL_LO) any_rail = 1'b1;
      if (v > o_hi) o_hi = v;
      if (v < o_lo) o_lo = v;
    end
  end

  // R1
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_ref == '0));

  // R2
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd2) |-> (out_valid == $past(in_valid, 2)));

  // R5
  p_equal_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_all_eq) |-> ##2 (out_ref == '0));

  // R7
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> $stable(out_ref));

  // R8
  p_centered_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !any_rail) |-> ((o_hi + o_lo == 0) || (o_hi + o_lo == 1)));
endmodule

bind cm_offset_inject cmoi_chk #(.W(W), .N(N)) u_chk (.*);

// File: tb/cm_offset_inject_tb.sv
module cm_offset_inject_tb;
  localparam int W = 16;
  localparam int N = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic [N*W-1:0] in_ref = '0;
  logic           out_valid;
  logic [N*W-1:0] out_ref;

  int n_chk  = 0;
  int n_fail = 0;

  // two-slot model of the pipeline
  logic           pv [2];
  logic [N*W-1:0] po [2];
  string          pr [2];
  logic [N*W-1:0] last_out;

  always #10 clk = ~clk;

  cm_offset_inject #(.W(W), .N(N)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ref(in_ref),
    .out_valid(out_valid), .out_ref(out_ref)
  );

  function automatic logic [N*W-1:0] model(input logic [N*W-1:0] r);
    int mx, mn, h, v;
    logic [N*W-1:0] o;
    mx = -100000; mn = 100000;
    for (int i = 0; i < N; i++) begin
      v = int'($signed(r[i*W +: W]));
      if (v > mx) mx = v;
      if (v < mn) mn = v;
    end
    h = (mx + mn) >>> 1;
    for (int i = 0; i < N; i++) begin
      v = int'($signed(r[i*W +: W])) - h;
      if (v > 32767) v = 32767;
      if (v < -32768) v = -32768;
      o[i*W +: W] = v[W-1:0];
    end
    return o;
  endfunction

  function automatic logic [N*W-1:0] pack3(input int a, input int b, input int c);
    logic [N*W-1:0] o;
    o[W-1:0] = a[W-1:0]; o[2*W-1:W] = b[W-1:0]; o[3*W-1:2*W] = c[W-1:0];
    return o;
  endfunction

  task automatic chk(input string req, input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one cycle: check the result due now, then drive new stimulus
  task automatic step(input logic v, input logic [N*W-1:0] r, input string req);
    @(negedge clk);
    chk("R2 out_valid", {47'd0, out_valid}, {47'd0, pv[1]});
    if (pv[1]) begin
      chk(pr[1], out_ref, po[1]);
      last_out = po[1];
    end else begin
      chk("R7 hold", out_ref, last_out);
    end
    pv[1] = pv[0]; po[1] = po[0]; pr[1] = pr[0];
    pv[0] = v; po[0] = model(r); pr[0] = req;
    in_valid = v;
    in_ref   = r;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset valid", {47'd0, out_valid}, '0);
    chk("R1 reset data", out_ref, '0);
    rst = 1'b0;
    pv[0] = 1'b0; pv[1] = 1'b0; last_out = '0;
  endtask

  initial begin
    pv[0] = 1'b0; pv[1] = 1'b0; po[0] = '0; po[1] = '0; pr[0] = ""; pr[1] = "";
    last_out = '0;
    void'($urandom(32'd20251));
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {47'd0, out_valid}, '0);
    chk("R1 reset data", out_ref, '0);
    rst = 1'b0;

    // R5 equal samples give zero
    step(1'b1, pack3(100, 100, 100), "R5 equal");
    step(1'b0, '0, "");
    step(1'b1, pack3(-32768, -32768, -32768), "R5 equal min");
    step(1'b1, pack3(32767, 32767, 32767), "R5 equal max");
    // R6 symmetric passes through
    step(1'b1, pack3(1000, -1000, 0), "R6 symmetric");
    step(1'b1, pack3(5, 3, -5), "R6 symmetric");
    // R3 floor rounding
    step(1'b1, pack3(3, 0, 0), "R3 floor pos");
    step(1'b1, pack3(-3, 0, 0), "R3 floor neg");
    // R4 positive rail
    step(1'b1, pack3(32767, -32768, 0), "R4 saturate");
    step(1'b1, pack3(-32768, 32767, 32767), "R4 saturate");
    // R7 input noise without strobe
    for (int k = 0; k < 6; k++) step(1'b0, {$urandom(), $urandom()}, "");

    // mid-run reset
    step(1'b1, pack3(1234, -50, 700), "R3 before reset");
    do_reset();
    step(1'b0, '0, "");

    // R9 back-to-back strobes and R3 random mix
    for (int k = 0; k < 1500; k++) begin
      logic [N*W-1:0] r;
      r = {$urandom(), $urandom()};
      if (k % 7 == 0) r[W-1:0] = r[2*W-1:W];
      step(($urandom() % 3) != 0, r, (k < 300) ? "R9 stream" : "R3 random");
    end
    repeat (3) step(1'b0, '0, "");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule